// File: doc/BRIEF.md
# Guest Interval Timer Match Unit

This block gives a guest context its own 64-bit time counter, derived from a free-running host counter plus a stored offset. The guest value is held back by a monotonic guard so that it never falls below the last value the unit recorded, even if the host counter jumps backward. A match register is compared against the guest counter, and when the counter crosses it the unit raises a single one-cycle interrupt request carrying an 8-bit vector taken from a control register. The control register also holds a mask bit that silences the timer.

Software reaches the unit through a single-cycle register port: address 0 is the guest counter, address 1 the match value, address 2 the control word, and address 3 reads as zero. Reads are combinational from the current state. A `suspend_i` input models the context being taken off the processor. While it is high, no request is raised and the recorded value is frozen. Deasserting it makes the next evaluation catch up on a match that was passed in the meantime.

While the unit is neither masked nor suspended, it evaluates on every cycle. A write in the same cycle as an evaluation is applied first. Each evaluation records the current guest value. The request fires only when the recorded value before that evaluation was still behind the match and the current value has reached it, using signed 64-bit differences.

Top module: `vtimer_match`

## Requirements
- R1: A read of address 0 returns host counter plus offset whenever that sum is strictly ahead of the last recorded value (signed 64-bit difference).
- R2: When host counter plus offset is not strictly ahead of the last recorded value, a read of address 0 returns the last recorded value. The recorded value only moves forward, except through a counter write.
- R3: A write to address 0 sets the offset to the written value minus the host counter and sets the recorded value to the written value. Later reads advance from there with the host counter.
- R4: Address 1 reads back the match value. Address 2 reads back the control word with the vector in bits 7:0 and the mask in bit 16. Written bits other than these are dropped and read as zero.
- R5: After reset the offset and match are 0, the control word reads 0x10000 (masked, vector 0), the recorded value equals the host counter, and no request is raised.
- R6: When an evaluation finds the recorded value behind the match and the current guest value at or past it, `irq_req_o` is high for exactly the next cycle with `irq_vec_o` equal to the control vector. It does not fire again for that match.
- R7: If the recorded value is already at or past the match when evaluated, no request is raised, even right after a match write.
- R8: While the mask bit is set, no request is raised and the recorded value does not advance. Clearing the mask after the counter has passed the match raises one request.
- R9: While `suspend_i` is high, no request is raised. On resume, a match crossed during suspension raises one request.
- R10: A register write lands before the evaluation of the same cycle. A counter write to a value at or past the match raises nothing, and a match write that falls between the recorded and current values fires in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cnt_i | input | 64 | Free-running host counter |
| suspend_i | input | 1 | High while the guest context is descheduled |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address (0 counter, 1 match, 2 control) |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data for the addressed register |
| irq_req_o | output | 1 | One-cycle timer interrupt request |
| irq_vec_o | output | 8 | Vector accompanying the request |

## Verification
The bench steps the host counter backward, both while the timer is masked and while it is evaluating. A guard that compared with the wrong sign, or against the wrong value, would then return a stale or regressed count. It places the match on the exact crossing value, at a value already passed, and between the recorded and current values inside the cycle of the write, so a compare with an off-by-one or with the write applied late would fire twice, fire for a stale match, or miss. It lets the counter cross the match while the mask is set and while the context is suspended. A design that advanced the recorded value in those windows would lose the request on unmask or resume, and one that ignored mask or suspend would fire early.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

    localparam int CNT_W    = 64;
    localparam int VEC_W    = 8;
    localparam int MASK_POS = 16;
    localparam int ADDR_W   = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_COUNT = 2'd0,
        RA_MATCH = 2'd1,
        RA_CTRL  = 2'd2,
        RA_SPARE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             masked;
        logic [VEC_W-1:0] vec;
    } ctrl_t;

    typedef struct packed {
        logic      we;
        reg_addr_e addr;
        cnt_t      data;
    } reg_wr_t;

    typedef enum logic [1:0] {
        CMP_IDLE,
        CMP_SPENT,
        CMP_HIT,
        CMP_WAIT
    } cmp_res_e;

    localparam ctrl_t CTRL_RST = '{masked: 1'b1, vec: '0};

    // signed (a - b) > 0
    function automatic logic ahead(input cnt_t a, input cnt_t b);
        cnt_t d;
        d = a - b;
        return !d[CNT_W-1] && (d != '0);
    endfunction

    // signed (a - b) >= 0
    function automatic logic not_behind(input cnt_t a, input cnt_t b);
        cnt_t d;
        d = a - b;
        return !d[CNT_W-1];
    endfunction

    function automatic cnt_t clamp_fwd(input cnt_t cand, input cnt_t floor_v);
        return ahead(cand, floor_v) ? cand : floor_v;
    endfunction

    function automatic ctrl_t word_to_ctrl(input cnt_t w);
        ctrl_t c;
        c.masked = w[MASK_POS];
        c.vec    = w[VEC_W-1:0];
        return c;
    endfunction

    function automatic cnt_t ctrl_to_word(input ctrl_t c);
        cnt_t w;
        w              = '0;
        w[MASK_POS]    = c.masked;
        w[VEC_W-1:0]   = c.vec;
        return w;
    endfunction

endpackage

// File: rtl/vtm_regfile.sv
module vtm_regfile
    import vtm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reg_wr_t wr,
    input  cnt_t    host_cnt,
    output cnt_t    offset_q,
    output cnt_t    offset_n,
    output cnt_t    match_q,
    output cnt_t    match_n,
    output ctrl_t   ctrl_q,
    output ctrl_t   ctrl_n,
    output logic    cnt_wr,
    output cnt_t    cnt_wdata
);

    logic match_wr;
    logic ctrl_wr;

    always_comb begin
        cnt_wr    = wr.we && (wr.addr == RA_COUNT);
        match_wr  = wr.we && (wr.addr == RA_MATCH);
        ctrl_wr   = wr.we && (wr.addr == RA_CTRL);
        cnt_wdata = wr.data;
    end

    // Post-write views: the same-cycle evaluation sees these.
    always_comb begin
        offset_n = cnt_wr   ? (wr.data - host_cnt) : offset_q;
        match_n  = match_wr ? wr.data              : match_q;
        ctrl_n   = ctrl_wr  ? word_to_ctrl(wr.data) : ctrl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
            match_q  <= '0;
            ctrl_q   <= CTRL_RST;
        end else begin
            offset_q <= offset_n;
            match_q  <= match_n;
            ctrl_q   <= ctrl_n;
        end
    end

    AST_MATCH_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        match_wr |=> (match_q == $past(wr.data)));    // R4

endmodule

// File: rtl/vtm_guard.sv
module vtm_guard
    import vtm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t host_cnt,
    input  cnt_t offset_q,
    input  cnt_t offset_n,
    input  logic cnt_wr,
    input  cnt_t cnt_wdata,
    input  logic eval_en,
    output cnt_t last_q,
    output cnt_t last_n,
    output cnt_t now_n,
    output cnt_t rd_view
);

    cnt_t guest_n;
    cnt_t guest_q;

    always_comb begin
        guest_n = host_cnt + offset_n;
        guest_q = host_cnt + offset_q;
        last_n  = cnt_wr ? cnt_wdata : last_q;
        now_n   = clamp_fwd(guest_n, last_n);
        rd_view = clamp_fwd(guest_q, last_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= host_cnt;
        end else begin
            last_q <= eval_en ? now_n : last_n;
        end
    end

    AST_LAST_NO_BACKSTEP: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> not_behind(last_q, $past(last_q)));    // R2

    AST_CNT_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (last_q == $past(cnt_wdata)));    // R3

    AST_IDLE_LAST_HELD: assert property (@(posedge clk) disable iff (rst)
        (!eval_en && !cnt_wr) |=> (last_q == $past(last_q)));    // R8

endmodule

// File: rtl/vtm_compare.sv
module vtm_compare
    import vtm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eval_en,
    input  cnt_t             last_n,
    input  cnt_t             now_n,
    input  cnt_t             match_n,
    input  logic [VEC_W-1:0] vec_n,
    output logic             irq_q,
    output logic [VEC_W-1:0] vec_q
);

    cmp_res_e res;

    always_comb begin
        if (!eval_en)
            res = CMP_IDLE;
        else if (not_behind(last_n, match_n))
            res = CMP_SPENT;
        else if (not_behind(now_n, match_n))
            res = CMP_HIT;
        else
            res = CMP_WAIT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= (res == CMP_HIT);
            vec_q <= vec_n;
        end
    end

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !eval_en |=> !irq_q);    // R8

endmodule

// File: rtl/vtimer_match.sv
module vtimer_match
    import vtm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [vtm_pkg::CNT_W-1:0] host_cnt_i,
    input  logic                      suspend_i,
    input  logic                      reg_we_i,
    input  logic [vtm_pkg::ADDR_W-1:0] reg_addr_i,
    input  logic [vtm_pkg::CNT_W-1:0] reg_wdata_i,
    output logic [vtm_pkg::CNT_W-1:0] reg_rdata_o,
    output logic                      irq_req_o,
    output logic [vtm_pkg::VEC_W-1:0] irq_vec_o
);

    reg_wr_t wr;
    cnt_t    offset_q, offset_n;
    cnt_t    match_q, match_n;
    ctrl_t   ctrl_q, ctrl_n;
    logic    cnt_wr;
    cnt_t    cnt_wdata;
    cnt_t    last_q, last_n, now_n, rd_view;
    logic    eval_en;

    always_comb begin
        wr.we   = reg_we_i;
        wr.addr = reg_addr_e'(reg_addr_i);
        wr.data = reg_wdata_i;
    end

    vtm_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .host_cnt  (host_cnt_i),
        .offset_q  (offset_q),
        .offset_n  (offset_n),
        .match_q   (match_q),
        .match_n   (match_n),
        .ctrl_q    (ctrl_q),
        .ctrl_n    (ctrl_n),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata)
    );

    assign eval_en = !suspend_i && !ctrl_n.masked;

    vtm_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .host_cnt  (host_cnt_i),
        .offset_q  (offset_q),
        .offset_n  (offset_n),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .eval_en   (eval_en),
        .last_q    (last_q),
        .last_n    (last_n),
        .now_n     (now_n),
        .rd_view   (rd_view)
    );

    vtm_compare u_cmp (
        .clk     (clk),
        .rst     (rst),
        .eval_en (eval_en),
        .last_n  (last_n),
        .now_n   (now_n),
        .match_n (match_n),
        .vec_n   (ctrl_n.vec),
        .irq_q   (irq_req_o),
        .vec_q   (irq_vec_o)
    );

    always_comb begin
        case (wr.addr)
            RA_COUNT: reg_rdata_o = rd_view;
            RA_MATCH: reg_rdata_o = match_q;
            RA_CTRL:  reg_rdata_o = ctrl_to_word(ctrl_q);
            default:  reg_rdata_o = '0;
        endcase
    end

    AST_REQ_REACHED_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> not_behind(last_q, match_q));    // R6

    AST_REQ_VEC_FROM_CTRL: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> (irq_vec_o == ctrl_q.vec));    // R6

    AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (rst)
        suspend_i |=> !irq_req_o);    // R9

endmodule

// File: tb/tb_vtimer_match.sv
module tb_vtimer_match;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] host = '0;
    logic        susp = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        irq;
    logic [7:0]  vec;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int          cyc;
        bit          is_rd;
        logic [63:0] val;
        logic [7:0]  vec;
        string       tag;
    } exp_t;

    exp_t sq[$];
    exp_t it;

    always #2.5 clk = ~clk;

    vtimer_match dut (
        .clk         (clk),
        .rst         (rst),
        .host_cnt_i  (host),
        .suspend_i   (susp),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_req_o   (irq),
        .irq_vec_o   (vec)
    );

    task automatic rst_cycle(input logic [63:0] h);
        @(posedge clk); #1;
        rst = 1'b1; host = h; we = 1'b0; addr = 2'd0; wdata = '0; susp = 1'b0;
        cyc++;
    endtask

    task automatic drive(input logic [63:0] h, input logic w, input logic [1:0] a,
                         input logic [63:0] d, input logic s);
        @(posedge clk); #1;
        rst = 1'b0; host = h; we = w; addr = a; wdata = d; susp = s;
        cyc++;
    endtask

    // read data belongs to the current cycle
    task automatic exp_rd(input logic [63:0] v, input string tag);
        exp_t e;
        e.cyc = cyc; e.is_rd = 1'b1; e.val = v; e.vec = '0; e.tag = tag;
        sq.push_back(e);
    endtask

    // request from this cycle's evaluation shows one cycle later
    task automatic exp_irq(input bit f, input logic [7:0] v, input string tag);
        exp_t e;
        e.cyc = cyc + 1; e.is_rd = 1'b0; e.val = {63'd0, f}; e.vec = v; e.tag = tag;
        sq.push_back(e);
    endtask

    // monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        while (sq.size() > 0 && sq[0].cyc <= cyc) begin
            it = sq.pop_front();
            checks++;
            if (it.is_rd) begin
                if (rdata !== it.val) begin
                    fails++;
                    $display("FAIL %s: read data actual 0x%0h expected 0x%0h", it.tag, rdata, it.val);
                end
            end else begin
                if (irq !== it.val[0] || (it.val[0] && vec !== it.vec)) begin
                    fails++;
                    $display("FAIL %s: irq/vec actual %0b/0x%0h expected %0b/0x%0h",
                             it.tag, irq, vec, it.val[0], it.vec);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_cycle(64'd1000);
        rst_cycle(64'd1000);
        rst_cycle(64'd1000);
        // R5 reset state
        drive(64'd1000, 0, 2'd0, 0, 0); exp_rd(64'd1000, "R5"); exp_irq(0, 0, "R5");
        drive(64'd1000, 0, 2'd2, 0, 0); exp_rd(64'h10000, "R5");
        drive(64'd1000, 0, 2'd1, 0, 0); exp_rd(64'd0, "R5");
        // R1 / R2 while masked
        drive(64'd1010, 0, 2'd0, 0, 0); exp_rd(64'd1010, "R1");
        drive(64'd990,  0, 2'd0, 0, 0); exp_rd(64'd1000, "R2");
        // R3 counter write
        drive(64'd2000, 1, 2'd0, 64'd5000, 0);
        drive(64'd2100, 0, 2'd0, 0, 0); exp_rd(64'd5100, "R3");
        // match write while masked
        drive(64'd2150, 1, 2'd1, 64'd5200, 0); exp_irq(0, 0, "R8");
        // unmask, vector 0x42, junk upper bits
        drive(64'd2150, 1, 2'd2, 64'hABCC_FF42, 0); exp_irq(0, 0, "R6");
        drive(64'd2160, 0, 2'd2, 0, 0); exp_rd(64'h42, "R4");
        drive(64'd2170, 0, 2'd1, 0, 0); exp_rd(64'd5200, "R4");
        // R6 exact crossing
        drive(64'd2200, 0, 2'd0, 0, 0); exp_rd(64'd5200, "R1"); exp_irq(1, 8'h42, "R6");
        drive(64'd2210, 0, 2'd0, 0, 0); exp_rd(64'd5210, "R1"); exp_irq(0, 0, "R6");
        // R2 host steps back while evaluating
        drive(64'd2100, 0, 2'd0, 0, 0); exp_rd(64'd5210, "R2"); exp_irq(0, 0, "R2");
        // R7 match behind recorded value
        drive(64'd2220, 1, 2'd1, 64'd5100, 0); exp_irq(0, 0, "R7");
        drive(64'd2300, 1, 2'd1, 64'd6000, 0); exp_irq(0, 0, "R7");
        // R10 counter write past match
        drive(64'd2400, 1, 2'd0, 64'd7000, 0); exp_irq(0, 0, "R10");
        drive(64'd2410, 1, 2'd2, 64'h10055, 0); exp_rd(64'h42, "R4"); exp_irq(0, 0, "R8");
        drive(64'd2420, 1, 2'd1, 64'd7100, 0); exp_irq(0, 0, "R8");
        // R8 crossing while masked
        drive(64'd2500, 0, 2'd2, 0, 0); exp_rd(64'h10055, "R4"); exp_irq(0, 0, "R8");
        drive(64'd2550, 0, 2'd0, 0, 0); exp_rd(64'd7150, "R1"); exp_irq(0, 0, "R8");
        drive(64'd2560, 1, 2'd2, 64'h55, 0); exp_irq(1, 8'h55, "R8");
        drive(64'd2570, 0, 2'd0, 0, 0); exp_irq(0, 0, "R8");
        // R9 suspend across crossing
        drive(64'd2600, 1, 2'd1, 64'd7300, 0); exp_irq(0, 0, "R9");
        drive(64'd2700, 0, 2'd0, 0, 1); exp_irq(0, 0, "R9");
        drive(64'd2800, 0, 2'd0, 0, 1); exp_irq(0, 0, "R9");
        drive(64'd2810, 0, 2'd0, 0, 0); exp_irq(1, 8'h55, "R9");
        drive(64'd2820, 0, 2'd0, 0, 0); exp_irq(0, 0, "R9");
        // R10 match write between recorded and current in one cycle
        drive(64'd2830, 1, 2'd1, 64'd7425, 0); exp_irq(1, 8'h55, "R10");
        drive(64'd2840, 0, 2'd3, 0, 0); exp_rd(64'd0, "R4"); exp_irq(0, 0, "R10");
        drive(64'd2850, 0, 2'd0, 0, 0);
        drive(64'd2860, 0, 2'd0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule